// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block carries out one PCIe configuration access at a time for a host that programs it through a small word-addressed register port. Software loads a 4-bit request kind, a packed bus/device/function/register address, write data and byte-lane strobes, then writes the start bit. The engine copies those fields at that moment. It presents one request to a downstream link interface with a valid/ready handshake, and then waits for a completion that carries a 3-bit status code and 32 bits of data.

When the access finishes, the start bit reads back as zero and a sticky done flag is set. The status register then holds the completion code and whether the request was non-posted. Software polls for "start reads 0 and done reads nonzero", reads the results, and clears done with a write-one before the next access. If no completion arrives within a programmable number of cycles, the engine ends the access itself: it reports Completer Abort and returns all-ones read data.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset the start bit, done flag, status word and read data all read 0, `req_valid_o` is low, and the timeout limit (word 8) reads its parameter default.
- R2: The register words are: 0 kind[3:0], 1 address, 2 write data, 3 strobe[3:0], 4 read data (read-only), 5 start (bit 0), 6 status (bit 0 non-posted, bits 9:7 completion code), 7 done (bit 0, write-1-to-clear) and 8 timeout limit. Address bits 31:28 and 1:0 always read back and go out as 0, which leaves bus 27:20, device 19:15, function 14:12 and register 11:2.
- R3: Writing 1 to start bit 0 while idle makes start read 1 and raises `req_valid_o` on the next cycle. The request carries the kind, address and data captured at that write, and it is held until `req_ready_i`.
- R4: Kinds 0x8 and 0x9 (reads) always send strobe 0xF. Kinds 0xA and 0xB (writes) send the programmed strobe.
- R5: For a kind with bit 3 set (non-posted), a `cpl_valid_i` pulse after the handshake clears start, sets done, and stores the completion code and non-posted bit 1. For read kinds it also loads read data with `cpl_data_i`; write kinds leave read data unchanged.
- R6: A kind with bit 3 clear is posted. It finishes on the handshake with code 0 and non-posted bit 0, and read data is left unchanged.
- R7: A start written while an access is in flight is ignored. Register writes made while busy do not change the request in flight.
- R8: Writing 1 to done bit 0 clears done. Writing 0 leaves it set.
- R9: A non-posted access that gets no completion finishes on the (L+1)-th cycle after the handshake, where L is the timeout limit. It reports code 4 (Completer Abort) and read data 0xFFFFFFFF.
- R10: Completion codes 0 (success), 1 (Unsupported Request), 2 (Configuration Retry) and 4 (Completer Abort) are recorded exactly as received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| req_valid_o | output | 1 | Request valid toward the link |
| req_ready_i | input | 1 | Link accepts the request |
| req_type_o | output | 4 | Request kind |
| req_addr_o | output | 32 | Packed configuration address |
| req_wdata_o | output | 32 | Write data |
| req_strb_o | output | 4 | Byte-lane strobes |
| cpl_valid_i | input | 1 | Completion arrives |
| cpl_status_i | input | 3 | Completion code |
| cpl_data_i | input | 32 | Completion read data |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- A link that stalls `req_ready_i` while software rewrites the address and strikes start again. A design that does not snapshot its fields at start would send a changed address, and one that honours the second start would issue a second request.
- Posted kinds. A design that waits for a completion on these would hang and never set done.
- A write completion. A design that loads read data on it would corrupt the last read result.
- The timeout, checked both before and after the limit expires. An off-by-many counter would finish too early or not at all.
- A done clear with bit 0 low. A design that clears on any write would lose the flag.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned DW     = 32;
  localparam int unsigned SW     = DW / 8;

  localparam logic [REG_AW-1:0] OFS_KIND  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_WDATA = 4'd2;
  localparam logic [REG_AW-1:0] OFS_STRB  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_RDATA = 4'd4;
  localparam logic [REG_AW-1:0] OFS_GO    = 4'd5;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_DONE  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_TMO   = 4'd8;

  localparam logic [2:0] CPL_OK = 3'd0;
  localparam logic [2:0] CPL_CA = 3'd4;

  localparam logic [DW-1:0] ADDR_KEEP = 32'h0FFF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  typedef struct packed {
    logic [3:0]    kind;
    logic [DW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [SW-1:0] strb;
  } pio_req_t;

  function automatic logic kind_nonposted(input logic [3:0] k);
    return k[3];
  endfunction

  function automatic logic kind_read(input logic [3:0] k);
    return k[3] & ~k[1];
  endfunction
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned TMO_DEF = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output pio_req_t          prog_o,
  output logic [TMO_W-1:0]  tmo_lim_o,
  output logic              go_o,
  output logic              done_clr_o
);
  pio_req_t         prog_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      tmo_q  <= TMO_W'(TMO_DEF);
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_KIND:  prog_q.kind  <= wdata_i[3:0];
        OFS_ADDR:  prog_q.addr  <= wdata_i & ADDR_KEEP;
        OFS_WDATA: prog_q.wdata <= wdata_i;
        OFS_STRB:  prog_q.strb  <= wdata_i[SW-1:0];
        OFS_TMO:   tmo_q        <= wdata_i[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  assign go_o       = wr_i && (addr_i == OFS_GO)   && wdata_i[0];
  assign done_clr_o = wr_i && (addr_i == OFS_DONE) && wdata_i[0];
  assign prog_o     = prog_q;
  assign tmo_lim_o  = tmo_q;
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             done_clr_i,
  input  pio_req_t         prog_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             req_ready_i,
  input  logic             cpl_valid_i,
  input  logic [2:0]       cpl_status_i,
  input  logic [DW-1:0]    cpl_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       code_o,
  output logic             np_o,
  output logic [DW-1:0]    rdata_o,
  output logic             req_valid_o,
  output pio_req_t         cur_o
);
  seq_state_e       state_q;
  pio_req_t         cur_q;
  logic [TMO_W-1:0] cnt_q;
  logic             done_q, np_q;
  logic [2:0]       code_q;
  logic [DW-1:0]    rdata_q;

  logic          fin, fin_np, fin_load;
  logic [2:0]    fin_code;
  logic [DW-1:0] fin_data;

  always_comb begin
    fin      = 1'b0;
    fin_np   = 1'b0;
    fin_load = 1'b0;
    fin_code = CPL_OK;
    fin_data = cpl_data_i;
    unique case (state_q)
      S_ISSUE: if (req_ready_i && !kind_nonposted(cur_q.kind)) fin = 1'b1;
      S_WAIT: begin
        fin_np = 1'b1;
        if (cpl_valid_i) begin
          fin      = 1'b1;
          fin_code = cpl_status_i;
          fin_load = kind_read(cur_q.kind);
        end else if (cnt_q >= tmo_lim_i) begin
          fin      = 1'b1;
          fin_code = CPL_CA;
          fin_load = 1'b1;
          fin_data = '1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      np_q    <= 1'b0;
      code_q  <= CPL_OK;
      rdata_q <= '0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go_i) begin
          cur_q   <= prog_i;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (req_ready_i && kind_nonposted(cur_q.kind)) begin
          state_q <= S_WAIT;
          cnt_q   <= '0;
        end
        S_WAIT: if (!fin) cnt_q <= cnt_q + 1'b1;
        default: state_q <= S_IDLE;
      endcase
      // completion outranks a same-cycle done clear
      if (fin) begin
        state_q <= S_IDLE;
        done_q  <= 1'b1;
        np_q    <= fin_np;
        code_q  <= fin_code;
        if (fin_load) rdata_q <= fin_data;
      end
    end
  end

  always_comb begin
    cur_o = cur_q;
    if (kind_read(cur_q.kind)) cur_o.strb = '1;
  end

  assign busy_o      = (state_q != S_IDLE);
  assign req_valid_o = (state_q == S_ISSUE);
  assign done_o      = done_q;
  assign np_o        = np_q;
  assign code_o      = code_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned TMO_DEF = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [3:0]        req_type_o,
  output logic [DW-1:0]     req_addr_o,
  output logic [DW-1:0]     req_wdata_o,
  output logic [SW-1:0]     req_strb_o,
  input  logic              cpl_valid_i,
  input  logic [2:0]        cpl_status_i,
  input  logic [DW-1:0]     cpl_data_i
);
  pio_req_t         prog, cur;
  logic [TMO_W-1:0] tmo_lim;
  logic             go, done_clr, busy, done, np;
  logic [2:0]       code;
  logic [DW-1:0]    rdata;

  cfg_pio_regs #(.TMO_W(TMO_W), .TMO_DEF(TMO_DEF)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .prog_o     (prog),
    .tmo_lim_o  (tmo_lim),
    .go_o       (go),
    .done_clr_o (done_clr)
  );

  cfg_pio_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .done_clr_i   (done_clr),
    .prog_i       (prog),
    .tmo_lim_i    (tmo_lim),
    .req_ready_i  (req_ready_i),
    .cpl_valid_i  (cpl_valid_i),
    .cpl_status_i (cpl_status_i),
    .cpl_data_i   (cpl_data_i),
    .busy_o       (busy),
    .done_o       (done),
    .code_o       (code),
    .np_o         (np),
    .rdata_o      (rdata),
    .req_valid_o  (req_valid_o),
    .cur_o        (cur)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_KIND:  reg_rdata_o[3:0]    = prog.kind;
      OFS_ADDR:  reg_rdata_o         = prog.addr;
      OFS_WDATA: reg_rdata_o         = prog.wdata;
      OFS_STRB:  reg_rdata_o[SW-1:0] = prog.strb;
      OFS_RDATA: reg_rdata_o         = rdata;
      OFS_GO:    reg_rdata_o[0]      = busy;
      OFS_STAT:  begin
        reg_rdata_o[9:7] = code;
        reg_rdata_o[0]   = np;
      end
      OFS_DONE:  reg_rdata_o[0]       = done;
      OFS_TMO:   reg_rdata_o[TMO_W-1:0] = tmo_lim;
      default: ;
    endcase
  end

  assign req_type_o  = cur.kind;
  assign req_addr_o  = cur.addr;
  assign req_wdata_o = cur.wdata;
  assign req_strb_o  = cur.strb;
endmodule

// File: rtl/cfg_pio_engine_chk.sv
module cfg_pio_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        done_i,
  input logic        req_valid_o,
  input logic        req_ready_i,
  input logic [3:0]  req_type_o,
  input logic [31:0] req_addr_o,
  input logic [3:0]  req_strb_o
);
  // R3
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !req_valid_o);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_type_o));
  // R5
  done_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);
  // R4
  read_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_type_o[3] && !req_type_o[1] |-> req_strb_o == 4'hF);
  // R2
  addr_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[1:0] == 2'b00) && (req_addr_o[31:28] == 4'h0));
endmodule

bind cfg_pio_engine cfg_pio_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .done_i      (done),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_type_o  (req_type_o),
  .req_addr_o  (req_addr_o),
  .req_strb_o  (req_strb_o)
);

// File: tb/cfg_pio_engine_bench.sv
module cfg_pio_engine_bench;
  localparam int TMO_DEF = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [3:0]  req_type;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_strb;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_rd = '0;
  logic [31:0] v;

  always #10 clk = ~clk;

  cfg_pio_engine #(.TMO_W(16), .TMO_DEF(TMO_DEF)) u_cfg_pio_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_type_o(req_type), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .req_strb_o(req_strb), .cpl_valid_i(cpl_valid),
    .cpl_status_i(cpl_status), .cpl_data_i(cpl_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_stat(input logic np, input logic [2:0] c);
    return {22'd0, c, 6'd0, np};
  endfunction

  function automatic logic [3:0] exp_strb(input logic [3:0] k, input logic [3:0] s);
    return (k[3] && !k[1]) ? 4'hF : s;
  endfunction

  // program, start, handshake after rdly, complete after cdly (or time out)
  task automatic run_txn(input logic [3:0] k, input logic [31:0] a, input logic [31:0] wd,
                         input logic [3:0] s, input int rdly, input int cdly,
                         input logic [2:0] st, input logic [31:0] cd, input bit tmo,
                         input int lim);
    wr(4'd0, {28'd0, k});
    wr(4'd1, a);
    wr(4'd2, wd);
    wr(4'd3, {28'd0, s});
    wr(4'd7, 32'd1);
    wr(4'd5, 32'd1);
    @(negedge clk);
    chk("R3 req_valid", {31'd0, req_valid}, 32'd1);
    chk("R3 req_type", {28'd0, req_type}, {28'd0, k});
    chk("R2 req_addr", req_addr, a & 32'h0FFF_FFFC);
    chk("R4 req_strb", {28'd0, req_strb}, {28'd0, exp_strb(k, s)});
    for (int i = 0; i < rdly; i++) @(negedge clk);
    req_ready = 1'b1;
    @(posedge clk); #1;
    req_ready = 1'b0;
    if (k[3]) begin
      if (tmo) begin
        repeat (lim + 4) @(posedge clk);
        exp_rd = 32'hFFFF_FFFF;
      end else begin
        for (int i = 0; i < cdly; i++) @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_status = st; cpl_data = cd;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        if (!k[1]) exp_rd = cd;
      end
    end
    rd(4'd5, v); chk("R5 start cleared", v, 32'd0);
    rd(4'd7, v); chk("R5 done set", v, 32'd1);
    rd(4'd6, v);
    if (!k[3])   chk("R6 posted status", v, exp_stat(1'b0, 3'd0));
    else if (tmo) chk("R9 timeout status", v, exp_stat(1'b1, 3'd4));
    else         chk("R10 status", v, exp_stat(1'b1, st));
    rd(4'd4, v);
    chk(tmo ? "R9 timeout rdata" : "R5 rdata", v, exp_rd);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    rd(4'd5, v); chk("R1 start", v, 32'd0);
    rd(4'd7, v); chk("R1 done", v, 32'd0);
    rd(4'd6, v); chk("R1 status", v, 32'd0);
    rd(4'd4, v); chk("R1 rdata", v, 32'd0);
    rd(4'd8, v); chk("R1 tmo default", v, TMO_DEF);
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    // R2 address masking
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R2 addr mask", v, 32'h0FFF_FFFC);

    // directed: read type0 success, write type1 UR, read type1 CRS
    run_txn(4'h8, 32'h0120_8004, 32'h0, 4'h3, 0, 2, 3'd0, 32'hCAFE_0001, 1'b0, 0);
    run_txn(4'hB, 32'h0550_0A10, 32'h1234_5678, 4'h6, 1, 1, 3'd1, 32'hDEAD_BEEF, 1'b0, 0);
    run_txn(4'h9, 32'h0FF0_0FFC, 32'h0, 4'h1, 2, 0, 3'd2, 32'h0BAD_F00D, 1'b0, 0);
    // R6 posted kind
    run_txn(4'h2, 32'h0000_0100, 32'hAAAA_5555, 4'hF, 0, 0, 3'd0, 32'h0, 1'b0, 0);

    // R7 restart and rewrite while busy
    wr(4'd0, 32'h8);
    wr(4'd1, 32'h0030_1008);
    wr(4'd7, 32'd1);
    wr(4'd5, 32'd1);
    wr(4'd1, 32'h0777_7770);
    wr(4'd0, 32'hA);
    wr(4'd5, 32'd1);
    @(negedge clk);
    chk("R7 addr kept", req_addr, 32'h0030_1008);
    chk("R7 kind kept", {28'd0, req_type}, 32'h8);
    req_ready = 1'b1; @(posedge clk); #1; req_ready = 1'b0;
    @(negedge clk);
    cpl_valid = 1'b1; cpl_status = 3'd4; cpl_data = 32'h1357_9BDF;
    @(posedge clk); #1; cpl_valid = 1'b0;
    exp_rd = 32'h1357_9BDF;
    @(negedge clk);
    chk("R7 no second request", {31'd0, req_valid}, 32'd0);
    rd(4'd5, v); chk("R7 idle after one", v, 32'd0);
    rd(4'd6, v); chk("R10 CA code", v, exp_stat(1'b1, 3'd4));
    // R8 done clear semantics
    wr(4'd7, 32'd0);
    rd(4'd7, v); chk("R8 write0 keeps", v, 32'd1);
    wr(4'd7, 32'd1);
    rd(4'd7, v); chk("R8 write1 clears", v, 32'd0);

    // R9 timeout: busy before limit, abort after
    wr(4'd8, 32'd10);
    wr(4'd0, 32'hA);
    wr(4'd5, 32'd1);
    @(negedge clk);
    req_ready = 1'b1; @(posedge clk); #1; req_ready = 1'b0;
    repeat (8) @(posedge clk);
    rd(4'd5, v); chk("R9 still busy", v, 32'd1);
    repeat (6) @(posedge clk);
    exp_rd = 32'hFFFF_FFFF;
    rd(4'd5, v); chk("R9 finished", v, 32'd0);
    rd(4'd6, v); chk("R9 CA", v, exp_stat(1'b1, 3'd4));
    rd(4'd4, v); chk("R9 ones", v, exp_rd);
    run_txn(4'h9, 32'h0100_0000, 32'h0, 4'h0, 0, 0, 3'd0, 32'h0, 1'b1, 10);
    wr(4'd8, 32'd200);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [3:0] k;
      logic [2:0] st;
      int sel;
      sel = $urandom_range(0, 9);
      k = (sel < 8) ? (4'h8 | 4'(sel[1:0])) : 4'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: st = 3'd0;
        1: st = 3'd1;
        2: st = 3'd2;
        default: st = 3'd4;
      endcase
      run_txn(k, $urandom, $urandom, 4'($urandom), $urandom_range(0, 3),
              $urandom_range(0, 5), st, $urandom, 1'b0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule